// File: doc/BRIEF.md
# Signed Integer to Double Converter

This block turns a signed integer into an IEEE-754 double-precision value and places it in the low 64 bits of a wide vector destination. The source is read as a 64-bit integer only when the core runs in 64-bit mode with a 64-bit operand size. In every other case the low 32 bits are sign-extended and converted. All 32-bit inputs fit in the 53-bit significand, so they convert exactly. A 64-bit input with more significant bits than that is rounded under a 2-bit rounding-control input, and the precision flag reports that bits were lost.

The bits above the converted lane follow one of two merge rules, chosen by a form-select input. In the legacy form, the destination is also the first source, so every upper bit keeps its old value. In the VEX form, bits 127:64 come from a separate first vector source and all bits from 128 upward are cleared. Inputs are sampled once when the input valid is high. The merged result and the flag appear one cycle later with an output valid.

Top module: `i2d_convert`

## Requirements
- R1: The source is treated as a 64-bit signed integer only when `mode64`=1 and `opsize_w`=1. Otherwise `src_int[31:0]` is sign-extended and converted, and bits 63:32 have no effect.
- R2: With `mode64`=0, `opsize_w`=1 has no effect: the result equals the 32-bit conversion of `src_int[31:0]`.
- R3: `dst_out[63:0]` holds the double: sign in bit 63, biased exponent (bias 1023) in bits 62:52, fraction without the hidden one in bits 51:0. An input of zero gives +0.0 (all 64 bits zero).
- R4: With `vex_form`=0, `dst_out[VEC_W-1:64]` equals `dst_prev[VEC_W-1:64]` as sampled with the input.
- R5: With `vex_form`=1, `dst_out[127:64]` equals `vsrc1[127:64]` and `dst_out[VEC_W-1:128]` is zero.
- R6: An inexact 64-bit result is rounded by `rc`: 00 to nearest with ties to even, 01 toward negative infinity, 10 toward positive infinity, 11 toward zero.
- R7: `inexact` is 1 exactly when rounding discards nonzero bits. It is always 0 for the 32-bit path.
- R8: The 64-bit input 0x8000000000000000 yields 0xC3E0000000000000 (exactly -2^63) with `inexact`=0.
- R9: Each input accepted with `in_valid`=1 produces `out_valid`=1 on the following clock edge. A cycle without `in_valid` gives `out_valid`=0 one cycle later. Reset clears `out_valid`, `dst_out` and `inexact`.
- R10: When rounding carries out of the significand, the exponent goes up by one. For example, 0x7FFFFFFFFFFFFFFF rounded to nearest gives 0x43E0000000000000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample the inputs this cycle |
| src_int | input | 64 | Integer source |
| mode64 | input | 1 | Core is in 64-bit mode |
| opsize_w | input | 1 | Operand-size (W) bit |
| vex_form | input | 1 | 1 = VEX merge rule, 0 = legacy merge rule |
| rc | input | 2 | Rounding control |
| dst_prev | input | VEC_W | Prior destination contents |
| vsrc1 | input | VEC_W | First vector source for the VEX form |
| out_valid | output | 1 | Result valid |
| dst_out | output | VEC_W | Merged destination |
| inexact | output | 1 | Precision flag |

## Verification
Any wrong internal value shows at the ports one cycle after the input is taken, because there is only one register stage. A wrong leading-zero count shows as a shifted exponent. A wrong guard or sticky bit shows as a result one unit in the last place off, or as a wrong `inexact`, on the tie and near-tie vectors under each rounding mode. A mixed-up merge select shows as old or cleared upper lanes on the very next output.

// File: rtl/i2d_pkg.sv
package i2d_pkg;
   localparam int DBL_W    = 64;
   localparam int FRAC_W   = 52;
   localparam int EXP_W    = 11;
   localparam int EXP_BIAS = 1023;

   typedef enum logic [1:0] {
      RC_NEAREST = 2'b00,
      RC_DOWN    = 2'b01,
      RC_UP      = 2'b10,
      RC_ZERO    = 2'b11
   } rc_e;
endpackage

// File: rtl/i2d_srcsel.sv
module i2d_srcsel #(
   parameter int WIDE_W   = 64,
   parameter int NARROW_W = 32
) (
   input  logic [WIDE_W-1:0] src,
   input  logic              mode64,
   input  logic              opsize_w,
   output logic              neg,
   output logic [WIDE_W-1:0] mag
);
   localparam int EXT_W = WIDE_W - NARROW_W;

   logic              wide_sel;
   logic [WIDE_W-1:0] ext;

   // R1/R2: the W bit counts only in 64-bit mode
   assign wide_sel = mode64 & opsize_w;
   assign ext      = wide_sel ? src
                              : {{EXT_W{src[NARROW_W-1]}}, src[NARROW_W-1:0]};
   assign neg      = ext[WIDE_W-1];
   // the most negative value maps onto itself as an unsigned magnitude
   assign mag      = neg ? (~ext + 1'b1) : ext;
endmodule

// File: rtl/i2d_norm.sv
module i2d_norm #(
   parameter int WIDE_W = 64,
   localparam int LZ_W  = $clog2(WIDE_W + 1)
) (
   input  logic [WIDE_W-1:0] mag,
   output logic              is_zero,
   output logic [LZ_W-1:0]   lz,
   output logic [WIDE_W-1:0] norm
);
   always_comb begin
      lz = LZ_W'(WIDE_W);
      for (int i = 0; i < WIDE_W; i++) begin
         if (mag[i]) lz = LZ_W'(WIDE_W - 1 - i);
      end
   end

   assign is_zero = (mag == '0);
   assign norm    = mag << lz;
endmodule

// File: rtl/i2d_round.sv
module i2d_round
   import i2d_pkg::*;
#(
   parameter int WIDE_W = 64,
   localparam int LZ_W  = $clog2(WIDE_W + 1),
   localparam int DROP  = WIDE_W - 1 - FRAC_W
) (
   input  logic [WIDE_W-1:0] norm,
   input  logic [LZ_W-1:0]   lz,
   input  logic              is_zero,
   input  logic              neg,
   input  logic [1:0]        rc,
   output logic [DBL_W-1:0]  dbl,
   output logic              inexact
);
   logic [FRAC_W-1:0] frac;
   logic              guard, sticky, lost, up;
   logic [FRAC_W:0]   sum;
   logic [EXP_W-1:0]  exp_v;

   generate
      if (DROP >= 2) begin : g_rounded
         assign frac   = norm[WIDE_W-2 -: FRAC_W];
         assign guard  = norm[DROP-1];
         assign sticky = |norm[DROP-2:0];
      end else begin : g_exact
         assign frac   = FRAC_W'({norm[WIDE_W-2:0], {(FRAC_W-WIDE_W+1){1'b0}}});
         assign guard  = 1'b0;
         assign sticky = 1'b0;
      end
   endgenerate

   assign lost = guard | sticky;

   // R6: round-up decision per mode
   always_comb begin
      unique case (rc_e'(rc))
         RC_NEAREST: up = guard & (sticky | frac[0]);
         RC_DOWN:    up = neg & lost;
         RC_UP:      up = ~neg & lost;
         default:    up = 1'b0;
      endcase
   end

   assign sum   = {1'b0, frac} + {{FRAC_W{1'b0}}, up};
   // R10: a carry out of the fraction bumps the exponent
   assign exp_v = EXP_W'(EXP_BIAS + WIDE_W - 1) - EXP_W'(lz) + EXP_W'(sum[FRAC_W]);

   assign dbl     = is_zero ? '0 : {neg, exp_v, sum[FRAC_W-1:0]};
   assign inexact = ~is_zero & lost;
endmodule

// File: rtl/i2d_convert.sv
module i2d_convert
   import i2d_pkg::*;
#(
   parameter int WIDE_W   = 64,
   parameter int NARROW_W = 32,
   parameter int VEC_W    = 256
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [63:0]      src_int,
   input  logic             mode64,
   input  logic             opsize_w,
   input  logic             vex_form,
   input  logic [1:0]       rc,
   input  logic [VEC_W-1:0] dst_prev,
   input  logic [VEC_W-1:0] vsrc1,
   output logic             out_valid,
   output logic [VEC_W-1:0] dst_out,
   output logic             inexact
);
   localparam int LANE_W  = DBL_W;
   localparam int N_LANES = VEC_W / LANE_W;
   localparam int LZ_W    = $clog2(WIDE_W + 1);

   generate
      if (WIDE_W != 64)            $error("WIDE_W must be 64");
      if (NARROW_W >= WIDE_W)      $error("NARROW_W must be below WIDE_W");
      if (VEC_W % LANE_W != 0)     $error("VEC_W must be a multiple of 64");
      if (N_LANES < 2)             $error("VEC_W must hold at least two lanes");
   endgenerate

   logic              neg, is_zero, inexact_c;
   logic [WIDE_W-1:0] mag, norm;
   logic [LZ_W-1:0]   lz;
   logic [DBL_W-1:0]  dbl;
   logic [VEC_W-1:0]  merged;

   i2d_srcsel #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_srcsel (
      .src(src_int), .mode64(mode64), .opsize_w(opsize_w), .neg(neg), .mag(mag)
   );

   i2d_norm #(.WIDE_W(WIDE_W)) u_norm (
      .mag(mag), .is_zero(is_zero), .lz(lz), .norm(norm)
   );

   i2d_round #(.WIDE_W(WIDE_W)) u_round (
      .norm(norm), .lz(lz), .is_zero(is_zero), .neg(neg), .rc(rc),
      .dbl(dbl), .inexact(inexact_c)
   );

   // R4/R5: lane merge
   for (genvar ln = 0; ln < N_LANES; ln++) begin : g_lane
      if (ln == 0) begin : g_low
         assign merged[LANE_W-1:0] = dbl;
      end else if (ln == 1) begin : g_mid
         assign merged[ln*LANE_W +: LANE_W] = vex_form ? vsrc1[ln*LANE_W +: LANE_W]
                                                       : dst_prev[ln*LANE_W +: LANE_W];
      end else begin : g_high
         assign merged[ln*LANE_W +: LANE_W] = vex_form ? '0
                                                       : dst_prev[ln*LANE_W +: LANE_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         dst_out   <= '0;
         inexact   <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            dst_out <= merged;
            inexact <= inexact_c;
         end
      end
   end
endmodule

// File: rtl/i2d_convert_chk.sv
module i2d_convert_chk #(
   parameter int VEC_W = 256
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic [63:0]      src_int,
   input logic             mode64,
   input logic             opsize_w,
   input logic             vex_form,
   input logic [VEC_W-1:0] dst_prev,
   input logic [VEC_W-1:0] vsrc1,
   input logic             out_valid,
   input logic [VEC_W-1:0] dst_out,
   input logic             inexact
);
   p_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   p_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && src_int == 64'd0 |=> dst_out[63:0] == 64'd0 && !inexact);
   p_narrow_exact_r7: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !(mode64 && opsize_w) |=> !inexact);
   p_w_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !mode64 |=> dst_out[63] == $past(src_int[31]));
   p_min_exact_r8: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && mode64 && opsize_w && src_int == 64'h8000_0000_0000_0000
      |=> dst_out[63:0] == 64'hC3E0_0000_0000_0000 && !inexact);
   p_legacy_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !vex_form |=> dst_out[VEC_W-1:64] == $past(dst_prev[VEC_W-1:64]));
   p_vex_mid_r5: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && vex_form |=> dst_out[127:64] == $past(vsrc1[127:64]));
   p_vex_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && vex_form |=> dst_out[VEC_W-1:128] == '0);
endmodule

bind i2d_convert i2d_convert_chk #(.VEC_W(VEC_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_int(src_int),
   .mode64(mode64), .opsize_w(opsize_w), .vex_form(vex_form),
   .dst_prev(dst_prev), .vsrc1(vsrc1), .out_valid(out_valid),
   .dst_out(dst_out), .inexact(inexact)
);

// File: tb/i2d_convert_bench.sv
`timescale 1ns/1ps
module i2d_convert_bench;
   localparam int VEC_W = 256;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             in_valid = 1'b0;
   logic [63:0]      src_int = '0;
   logic             mode64 = 1'b0, opsize_w = 1'b0, vex_form = 1'b0;
   logic [1:0]       rc = 2'b00;
   logic [VEC_W-1:0] dst_prev = '0, vsrc1 = '0;
   logic             out_valid, inexact;
   logic [VEC_W-1:0] dst_out;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   typedef struct {
      logic [VEC_W-1:0] data;
      logic             flag;
      string            tag;
   } item_t;
   item_t sb[$];

   always #10 clk = ~clk;

   i2d_convert #(.VEC_W(VEC_W)) u_i2d_convert (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_int(src_int),
      .mode64(mode64), .opsize_w(opsize_w), .vex_form(vex_form), .rc(rc),
      .dst_prev(dst_prev), .vsrc1(vsrc1), .out_valid(out_valid),
      .dst_out(dst_out), .inexact(inexact)
   );

   task automatic drive(input logic [63:0] s, input logic m, input logic w,
                        input logic vx, input logic [1:0] r,
                        input logic [63:0] exp_lo, input logic exp_fl,
                        input string tag);
      logic [VEC_W-1:0] pv, v1;
      item_t it;
      pv = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
      v1 = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
      @(negedge clk);
      src_int = s; mode64 = m; opsize_w = w; vex_form = vx; rc = r;
      dst_prev = pv; vsrc1 = v1; in_valid = 1'b1;
      it.data = vx ? {{(VEC_W-128){1'b0}}, v1[127:64], exp_lo}
                   : {pv[VEC_W-1:64], exp_lo};
      it.flag = exp_fl;
      it.tag  = tag;
      sb.push_back(it);
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n && out_valid && !done) begin
         if (sb.size() == 0) begin
            n_tests++; n_fail++;
            $display("FAIL R9 unexpected out_valid: actual 1 expected 0");
         end else begin
            item_t it;
            it = sb.pop_front();
            n_tests++;
            if (dst_out !== it.data || inexact !== it.flag) begin
               n_fail++;
               $display("FAIL %s: actual %h/%b expected %h/%b",
                        it.tag, dst_out, inexact, it.data, it.flag);
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R9: reset state
      n_tests++;
      if (out_valid !== 1'b0 || dst_out !== '0 || inexact !== 1'b0) begin
         n_fail++;
         $display("FAIL R9 reset: actual %b/%h/%b expected 0/0/0", out_valid, dst_out, inexact);
      end
      rst_n = 1'b1;

      // R3 zero, R8 min value
      drive(64'd0, 1, 1, 0, 2'b00, 64'd0, 0, "R3 zero");
      drive(64'h8000_0000_0000_0000, 1, 1, 1, 2'b01, 64'hC3E0_0000_0000_0000, 0, "R8 min");
      // R1 width select
      drive(64'h1234_5678_0000_0005, 1, 0, 0, 2'b00, 64'h4014_0000_0000_0000, 0, "R1 narrow w0");
      drive(64'h0000_0001_0000_0000, 1, 1, 1, 2'b00, 64'h41F0_0000_0000_0000, 0, "R1 wide");
      // R2 W ignored outside 64-bit mode
      drive(64'hFFFF_FFFF_8000_0000, 0, 1, 0, 2'b11, 64'hC1E0_0000_0000_0000, 0, "R2 w ignored");
      drive(64'h0000_0001_0000_0000, 0, 1, 1, 2'b00, 64'd0, 0, "R2 high bits ignored");
      // R6/R7 rounding, ties
      drive(64'h0020_0000_0000_0001, 1, 1, 0, 2'b00, 64'h4340_0000_0000_0000, 1, "R6 RNE tie even");
      drive(64'h0020_0000_0000_0003, 1, 1, 1, 2'b00, 64'h4340_0000_0000_0002, 1, "R6 RNE tie odd");
      drive(64'h0020_0000_0000_0001, 1, 1, 0, 2'b10, 64'h4340_0000_0000_0001, 1, "R6 up pos");
      drive(64'h0020_0000_0000_0001, 1, 1, 1, 2'b01, 64'h4340_0000_0000_0000, 1, "R6 down pos");
      drive(-64'sd9007199254740993, 1, 1, 0, 2'b01, 64'hC340_0000_0000_0001, 1, "R6 down neg");
      drive(-64'sd9007199254740993, 1, 1, 1, 2'b10, 64'hC340_0000_0000_0000, 1, "R6 up neg");
      drive(-64'sd9007199254740993, 1, 1, 0, 2'b11, 64'hC340_0000_0000_0000, 1, "R6 zero neg");
      // R10 carry into exponent, R7 flag
      drive(64'h7FFF_FFFF_FFFF_FFFF, 1, 1, 0, 2'b00, 64'h43E0_0000_0000_0000, 1, "R10 carry");
      drive(64'h7FFF_FFFF_FFFF_FFFF, 1, 1, 1, 2'b11, 64'h43DF_FFFF_FFFF_FFFF, 1, "R7 truncate");
      drive(64'h0020_0000_0000_0002, 1, 1, 0, 2'b10, 64'h4340_0000_0000_0001, 0, "R7 exact wide");

      // idle cycle, R9
      @(negedge clk); in_valid = 1'b0;
      @(negedge clk);
      n_tests++;
      if (out_valid !== 1'b0) begin
         n_fail++;
         $display("FAIL R9 idle: actual %b expected 0", out_valid);
      end

      // random narrow inputs: exact (R1, R7), both forms (R4, R5)
      for (int k = 0; k < 40; k++) begin
         logic [63:0] s;
         logic        m, w;
         int          iv;
         s  = {$urandom, $urandom};
         m  = $urandom % 2;
         w  = m ? 1'b0 : 1'(($urandom % 2));
         iv = $signed(s[31:0]);
         drive(s, m, w, 1'($urandom % 2), 2'($urandom % 4),
               $realtobits(real'(iv)), 0, "R1 random narrow");
      end
      // random wide inputs within 52 bits: exact (R3)
      for (int k = 0; k < 40; k++) begin
         logic [51:0] r;
         longint      x;
         r = {20'($urandom), $urandom};
         x = longint'({{12{r[51]}}, r});
         drive(64'(x), 1, 1, 1'($urandom % 2), 2'($urandom % 4),
               $realtobits(real'(x)), 0, "R3 random wide");
      end

      @(negedge clk); in_valid = 1'b0;
      repeat (3) @(negedge clk);
      done = 1'b1;
      n_tests++;
      if (sb.size() != 0) begin
         n_fail++;
         $display("FAIL R9 missing outputs: actual %0d pending expected 0", sb.size());
      end
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule